// File: doc/BRIEF.md
# Event Interrupt Status and Mask Unit

This block collects four hardware event sources of a block-cipher accelerator (encryption finished, encryption started, DMA channel A finished, DMA channel B finished) into a raw status vector, gates it with a mask and drives one registered interrupt line. Software reads the raw and the masked status. It can force or acknowledge status bits through write-only set and clear registers, and it edits the mask either by a full write or through write-only mask-set and mask-clear registers.

Each source also has an auto-acknowledge enable. When its enable is high, any read or write of the most significant word of the cipher's data registers clears the status bit. A neighbouring block signals such an access on a single strobe. A streaming loop that moves data through those registers therefore never has to write an explicit acknowledge. A hardware event always wins over any clear that lands in the same cycle, so no event is lost.

The bus is a single-cycle register port with word addresses. Reads return data combinationally in the request cycle. Writes take effect at the next clock edge.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the raw status, the mask and `irq_o` are all 0.
- R2: A high bit on `evt_i` sets the matching raw status bit at the next clock edge. The bit order is 0 encryption done, 1 encryption start, 2 channel A done, 3 channel B done.
- R3: A write to the set register (word address 3) sets each raw bit whose write-data bit is 1. Bits written 0 leave the status unchanged.
- R4: A write to the clear register (word address 4) clears each raw bit whose write-data bit is 1. Bits written 0 leave the status unchanged.
- R5: A write to the mask register (word address 0) replaces the mask. A write to mask-set (address 5) sets the selected mask bits and a write to mask-clear (address 6) clears them. Bits written 0 leave the mask unchanged.
- R6: A read of the masked status (word address 2) returns the raw status ANDed with the mask. A read of address 1 returns the raw status and a read of address 0 returns the mask.
- R7: When `data_w3_acc_i` is high, every raw bit whose `autoclr_en_i` bit is 1 clears at the next edge. Bits whose enable is 0 are unaffected.
- R8: When a hardware event and a clear (a clear-register write or an auto-clear) hit the same bit in the same cycle, the bit ends up set.
- R9: `irq_o` is a register holding the OR of the masked status bits. It follows a change of the status or the mask one clock later.
- R10: Bits 31:4 of every readable register read 0. The write-only addresses 3 to 6 and unmapped addresses read 0. Writes to the status addresses 1 and 2 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 write, 0 read |
| addr_i | input | ADDR_W (4) | Word address |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid in the request cycle |
| evt_i | input | N_SRC (4) | Hardware event pulses, one per source |
| data_w3_acc_i | input | 1 | Access to data word 3 (text, buffer or XOR views) |
| autoclr_en_i | input | N_SRC (4) | Per-source auto-clear enables |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong raw or mask bit shows up on a status read in the cycle after the faulty edge. It also moves `irq_o` one edge after that. The bench therefore reads both status views after every stimulus and checks `irq_o` at exactly the edge after a status change as well as the edge before it. Collision cycles pair an event with each kind of clear, because a reversed priority loses a bit and nothing else at the ports reveals it.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

  typedef enum logic [2:0] {
    REG_MASK  = 3'd0,
    REG_RAW   = 3'd1,
    REG_MSTAT = 3'd2,
    REG_SET   = 3'd3,
    REG_CLR   = 3'd4,
    REG_MSET  = 3'd5,
    REG_MCLR  = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic mask_wr;
    logic set_wr;
    logic clr_wr;
    logic mset_wr;
    logic mclr_wr;
  } wr_strb_t;

  typedef struct packed {
    logic rd_mask;
    logic rd_raw;
    logic rd_mstat;
  } rd_sel_t;

endpackage

// File: rtl/evt_irq_decode.sv
module evt_irq_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strb_t          wr_o,
  output rd_sel_t           rd_o
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_sel_e s);
    return a == ADDR_W'(s);
  endfunction

  logic wr_acc, rd_acc;
  assign wr_acc = req_i & we_i;
  assign rd_acc = req_i & ~we_i;

  always_comb begin
    wr_o.mask_wr = wr_acc & hit(addr_i, REG_MASK);
    wr_o.set_wr  = wr_acc & hit(addr_i, REG_SET);
    wr_o.clr_wr  = wr_acc & hit(addr_i, REG_CLR);
    wr_o.mset_wr = wr_acc & hit(addr_i, REG_MSET);
    wr_o.mclr_wr = wr_acc & hit(addr_i, REG_MCLR);
    rd_o.rd_mask  = rd_acc & hit(addr_i, REG_MASK);
    rd_o.rd_raw   = rd_acc & hit(addr_i, REG_RAW);
    rd_o.rd_mstat = rd_acc & hit(addr_i, REG_MSTAT);
  end

endmodule

// File: rtl/evt_irq_src_bank.sv
module evt_irq_src_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic stat_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    stat_o <= 1'b0;
    else if (set_i) stat_o <= 1'b1;  // set beats clear
    else if (clr_i) stat_o <= 1'b0;
  end
endmodule

module evt_irq_src_bank #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] evt_i,
  input  logic             sw_set_i,
  input  logic             sw_clr_i,
  input  logic [N_SRC-1:0] sw_bits_i,
  input  logic             acc_i,
  input  logic [N_SRC-1:0] acc_en_i,
  output logic [N_SRC-1:0] raw_o
);
  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    logic set_k, clr_k;
    assign set_k = evt_i[k] | (sw_set_i & sw_bits_i[k]);
    assign clr_k = (sw_clr_i & sw_bits_i[k]) | (acc_i & acc_en_i[k]);
    evt_irq_src_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (set_k),
      .clr_i  (clr_k),
      .stat_o (raw_o[k])
    );
  end
endmodule

// File: rtl/evt_irq_mask_reg.sv
module evt_irq_mask_reg #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [N_SRC-1:0] bits_i,
  output logic [N_SRC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_o <= '0;
    else if (wr_i)  mask_o <= bits_i;
    else if (set_i) mask_o <= mask_o | bits_i;
    else if (clr_i) mask_o <= mask_o & ~bits_i;
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              data_w3_acc_i,
  input  logic [N_SRC-1:0]  autoclr_en_i,
  output logic              irq_o
);

  wr_strb_t         wr;
  rd_sel_t          rd;
  logic [N_SRC-1:0] raw_q, mask_q, wbits;
  logic             unused_wdata;

  assign wbits        = wdata_i[N_SRC-1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:N_SRC];

  evt_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_i  (req_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wr_o   (wr),
    .rd_o   (rd)
  );

  evt_irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .sw_set_i  (wr.set_wr),
    .sw_clr_i  (wr.clr_wr),
    .sw_bits_i (wbits),
    .acc_i     (data_w3_acc_i),
    .acc_en_i  (autoclr_en_i),
    .raw_o     (raw_q)
  );

  evt_irq_mask_reg #(.N_SRC(N_SRC)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr.mask_wr),
    .set_i  (wr.mset_wr),
    .clr_i  (wr.mclr_wr),
    .bits_i (wbits),
    .mask_o (mask_q)
  );

  always_comb begin
    rdata_o = '0;
    if (rd.rd_mask)  rdata_o = DATA_W'(mask_q);
    if (rd.rd_raw)   rdata_o = DATA_W'(raw_q);
    if (rd.rd_mstat) rdata_o = DATA_W'(raw_q & mask_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |(raw_q & mask_q);
  end

endmodule

// File: rtl/evt_irq_ctrl_chk.sv
module evt_irq_ctrl_chk #(
  parameter int unsigned N_SRC  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_SRC-1:0]  evt_i,
  input logic              data_w3_acc_i,
  input logic [N_SRC-1:0]  autoclr_en_i,
  input logic              irq_o,
  input logic [N_SRC-1:0]  raw_q,
  input logic [N_SRC-1:0]  mask_q
);
  logic set_hit, clr_hit, mset_hit, rd_any;
  assign set_hit  = req_i && we_i && addr_i == ADDR_W'(3);
  assign clr_hit  = req_i && we_i && addr_i == ADDR_W'(4);
  assign mset_hit = req_i && we_i && addr_i == ADDR_W'(5);
  assign rd_any   = req_i && !we_i;

  // R8
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((raw_q & $past(evt_i)) == $past(evt_i)));

  // R4
  clr_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_hit && evt_i == '0) |=> ((raw_q & $past(wdata_i[N_SRC-1:0])) == '0));

  // R7
  autoclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_w3_acc_i && evt_i == '0 && !set_hit) |=> ((raw_q & $past(autoclr_en_i)) == '0));

  // R5
  mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mset_hit |=> ((mask_q & $past(wdata_i[N_SRC-1:0])) == $past(wdata_i[N_SRC-1:0])));

  // R9
  irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(raw_q & mask_q))));

  // R6
  mstat_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && addr_i == ADDR_W'(2)) |-> (rdata_o == DATA_W'(raw_q & mask_q)));

  // R10
  wo_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_any && addr_i >= ADDR_W'(3)) |-> (rdata_o == '0));
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
  .N_SRC(N_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .we_i          (we_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .evt_i         (evt_i),
  .data_w3_acc_i (data_w3_acc_i),
  .autoclr_en_i  (autoclr_en_i),
  .irq_o         (irq_o),
  .raw_q         (raw_q),
  .mask_q        (mask_q)
);

// File: tb/evt_irq_ctrl_tb.sv
`timescale 1ns/1ps
module evt_irq_ctrl_tb;
  localparam int unsigned ADDR_W = 4;
  localparam logic [3:0] A_MASK = 0, A_RAW = 1, A_MSTAT = 2, A_SET = 3,
                         A_CLR = 4, A_MSET = 5, A_MCLR = 6;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0, data_w3_acc_i = 0;
  logic [3:0]  addr_i = '0, evt_i = '0, autoclr_en_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_o;
  int          tests = 0, fails = 0;
  bit          done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  evt_irq_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_i(evt_i), .data_w3_acc_i(data_w3_acc_i),
    .autoclr_en_i(autoclr_en_i), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one clock cycle of stimulus, released at the next falling edge
  task automatic cyc(input logic wr, input logic [3:0] a, input logic [31:0] d,
                     input logic [3:0] ev, input logic acc);
    @(negedge clk_i);
    req_i = wr; we_i = wr; addr_i = a; wdata_i = d; evt_i = ev; data_w3_acc_i = acc;
    @(negedge clk_i);
    req_i = 0; we_i = 0; evt_i = '0; data_w3_acc_i = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 4'h0, 1'b0);
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    req_i = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_RAW, d);   chk("R1 raw", d, 0);
    rd(A_MASK, d);  chk("R1 mask", d, 0);
    rd(A_MSTAT, d); chk("R1 mstat", d, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_events();
    logic [31:0] d;
    logic [3:0]  acc_exp = '0;
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 4'h0, 0, 4'(1 << k), 1'b0);
      acc_exp |= 4'(1 << k);
      rd(A_RAW, d); chk($sformatf("R2 evt bit %0d", k), d, {28'b0, acc_exp});
    end
    wr(A_CLR, 32'h5); rd(A_RAW, d); chk("R4 clear 0x5", d, 32'hA);
    wr(A_CLR, 32'h0); rd(A_RAW, d); chk("R4 clear zero", d, 32'hA);
    wr(A_SET, 32'h0); rd(A_RAW, d); chk("R3 set zero", d, 32'hA);
    wr(A_SET, 32'h1); rd(A_RAW, d); chk("R3 set 0x1", d, 32'hB);
    wr(A_CLR, 32'hF); rd(A_RAW, d); chk("R4 clear all", d, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_MASK, 32'h3); rd(A_MASK, d); chk("R5 mask write", d, 32'h3);
    wr(A_MSET, 32'h8); rd(A_MASK, d); chk("R5 mask set", d, 32'hB);
    wr(A_MCLR, 32'h1); rd(A_MASK, d); chk("R5 mask clear", d, 32'hA);
    wr(A_MSET, 32'h0); wr(A_MCLR, 32'h0);
    rd(A_MASK, d); chk("R5 zero bits", d, 32'hA);
    wr(A_SET, 32'h6);
    rd(A_MSTAT, d); chk("R6 masked", d, 32'h2);
    rd(A_RAW, d);   chk("R6 raw view", d, 32'h6);
    wr(A_RAW, 32'hF); wr(A_MSTAT, 32'hF);
    rd(A_RAW, d);   chk("R10 status write ignored", d, 32'h6);
    wr(A_CLR, 32'hF); wr(A_MASK, 32'h0);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_MASK, 32'hF);
    wr(A_SET, 32'h4);           // raw updated at this edge
    chk("R9 irq lag", {31'b0, irq_o}, 0);
    @(negedge clk_i);
    chk("R9 irq rise", {31'b0, irq_o}, 1);
    wr(A_MCLR, 32'h4);
    chk("R9 irq hold", {31'b0, irq_o}, 1);
    @(negedge clk_i);
    chk("R9 irq masked off", {31'b0, irq_o}, 0);
    wr(A_MSET, 32'h4); @(negedge clk_i);
    chk("R9 irq back", {31'b0, irq_o}, 1);
    wr(A_CLR, 32'h4); @(negedge clk_i);
    chk("R9 irq after clear", {31'b0, irq_o}, 0);
    rd(A_RAW, d); chk("R9 raw empty", d, 0);
    wr(A_MASK, 32'h0);
  endtask

  task automatic t_autoclr();
    logic [31:0] d;
    wr(A_SET, 32'hF);
    autoclr_en_i = 4'h5;
    cyc(1'b0, 4'h0, 0, 4'h0, 1'b1);
    rd(A_RAW, d); chk("R7 autoclr 0x5", d, 32'hA);
    autoclr_en_i = 4'hA;
    @(negedge clk_i); @(negedge clk_i);
    rd(A_RAW, d); chk("R7 no strobe", d, 32'hA);
    autoclr_en_i = 4'h0;
    cyc(1'b0, 4'h0, 0, 4'h0, 1'b1);
    rd(A_RAW, d); chk("R7 enable off", d, 32'hA);
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_priority();
    logic [31:0] d;
    cyc(1'b1, A_CLR, 32'h1, 4'h1, 1'b0);
    rd(A_RAW, d); chk("R8 event vs clear write", d, 32'h1);
    autoclr_en_i = 4'hF;
    cyc(1'b0, 4'h0, 0, 4'h2, 1'b1);
    rd(A_RAW, d); chk("R8 event vs autoclr", d, 32'h2);
    autoclr_en_i = 4'h0;
    wr(A_CLR, 32'hF);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_SET, 32'hFFFF_FFF0);
    rd(A_RAW, d);  chk("R10 upper set bits ignored", d, 32'h0);
    wr(A_SET, 32'hFFFF_FFFF);
    rd(A_RAW, d);  chk("R10 raw upper zero", d, 32'hF);
    rd(A_MASK, d); chk("R10 mask upper zero", d, 32'hF);
    for (int a = 3; a < 16; a++) begin
      rd(4'(a), d); chk($sformatf("R10 addr %0d reads 0", a), d, 0);
    end
    wr(A_CLR, 32'hF); wr(A_MASK, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_events();
    t_mask();
    t_irq();
    t_autoclr();
    t_priority();
    t_reserved();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule